// File: doc/BRIEF.md
# Per-Channel Switched Serial Output Stage

This block produces four time-division serial output streams. Each frame holds 32 slots of eight bits, and each bit lasts two clock cycles. Every output slot has its own 16-bit connection entry, made of a low byte and a high byte. The high byte decides two things for the slot. First, whether the low byte is sent as a constant or is used as a 7-bit data-memory address, so that switched traffic goes out. Second, whether the slot drives its line at all or leaves it released. A global force-processor input makes every slot send its low byte with the driver on. A master drive-enable input turns every driver off, whatever the entries hold.

The connection entry and the data byte for slot c are fetched during slot c-1, one stream after another. The result is staged and then loaded into a per-stream shifter at the slot boundary. A frame pulse realigns the frame counter at any time.

Both memory read ports have a fixed latency of one cycle: data appears on the cycle after the read enable. They have no back-pressure and no valid/ready handshake, because the slot schedule leaves room for every read. The serial outputs are continuous and take no back-pressure either.

Top module: `tsw_out_stage`

## Requirements
- R1: While `rst_n` is low, and for the first slot after it rises, every `tx_en` bit is 0.
- R2: In connection mode (high-byte bit 2 = 0), the slot carries the data-memory byte at the address in low-byte bits 6:0. Bits 6:5 are the source stream and bits 4:0 the source channel; low-byte bit 7 is ignored.
- R3: In processor mode (high-byte bit 2 = 1), the slot carries the low byte itself.
- R4: High-byte bit 0 is the slot's driver enable. When it is 0, `tx_en` for that stream stays 0 for the whole slot.
- R5: When `force_proc` is 1, every slot acts as if high-byte bits 2 and 0 were both 1.
- R6: When `drive_enable` is 0, all `tx_en` bits are 0, whatever the entries and `force_proc` hold.
- R7: Slot c occupies frame positions 16c to 16c+15. Its byte is sent MSB first, each bit held for two cycles, and `tx_en` is constant across the slot.
- R8: During slot c-1 (wrapping from 31 to 0), the connection entry of slot c is read once per stream at address {stream[1:0], c[4:0]}. The two memory ports are never read in the same cycle.
- R9: Several output slots that name the same source all carry that source byte in the same frame (broadcast).
- R10: The cycle after a cycle with `frame_pulse` high is frame position 0. From slot 1 of that frame onward, the output is correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, two cycles per serial bit |
| rst_n | input | 1 | Asynchronous active-low reset; forces all drivers off |
| frame_pulse | input | 1 | Frame realignment; the next cycle is frame position 0 |
| force_proc | input | 1 | Global processor mode for every slot |
| drive_enable | input | 1 | Master driver enable; 0 releases all streams |
| cm_re | output | 1 | Connection-memory read enable |
| cm_addr | output | 7 | Connection-memory address {stream, slot} |
| cm_rdata | input | 16 | Connection entry, valid the cycle after `cm_re` |
| dm_re | output | 1 | Data-memory read enable |
| dm_addr | output | 7 | Data-memory address {stream, channel} |
| dm_rdata | input | 8 | Data byte, valid the cycle after `dm_re` |
| tx_data | output | 4 | Serial data, one bit per stream; meaningful only where `tx_en` is 1 |
| tx_en | output | 4 | Per-stream driver enable for the current slot |

## Verification
The hardest case to reach is a frame pulse that arrives in the middle of a slot. The fetch schedule is then cut short part-way, and the stage holds a mix of old and new bytes. The bench drives the pulse at an arbitrary frame position, restarts its own frame count from that pulse, and checks slot 1 of the first complete frame that follows. The channel-0 slot and the last slot, where the fetch address wraps, are covered by vectors placed on those slots. The bench also watches the early-fetch address for the whole run.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  localparam int NSTREAMS = 4;
  localparam int NCH      = 32;
  localparam int BITS     = 8;
  localparam int CPB      = 2;
  localparam int SW       = $clog2(NSTREAMS);
  localparam int CHW      = $clog2(NCH);
  localparam int AW       = SW + CHW;
  localparam int SLOT     = BITS * CPB;
  localparam int SLW      = $clog2(SLOT);
  localparam int POSW     = CHW + SLW;
  localparam int CMW      = 2 * BITS;
  // high-byte field positions
  localparam int HI_SRC   = 2;
  localparam int HI_DRV   = 0;
endpackage

// File: rtl/tsw_slot_timer.sv
module tsw_slot_timer #(
  parameter int POSW = tsw_pkg::POSW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_pulse,
  output logic [POSW-1:0] pos
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pos <= '0;
    else if (frame_pulse) pos <= '0;
    else                  pos <= pos + 1'b1;
  end
endmodule

// File: rtl/tsw_chan_fetch.sv
module tsw_chan_fetch
  import tsw_pkg::*;
#(
  parameter int NS = NSTREAMS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [POSW-1:0]         pos,
  input  logic                    load,
  input  logic                    frame_pulse,
  input  logic                    force_proc,
  output logic                    cm_re,
  output logic [AW-1:0]           cm_addr,
  input  logic [CMW-1:0]          cm_rdata,
  output logic                    dm_re,
  output logic [AW-1:0]           dm_addr,
  input  logic [BITS-1:0]         dm_rdata,
  output logic [NS-1:0][BITS-1:0] stage_byte,
  output logic [NS-1:0]           stage_oe
);
  logic [SLW-1:0] step, grp, ph;
  logic [CHW-1:0] nxt_ch;
  logic           in_rng, wr_now;
  logic [SW-1:0]  wr_idx;
  logic [CMW-1:0] ent_q;
  logic           sel_low_q, oe_q;
  logic [NS-1:0]  wr_mask;

  assign step   = pos[SLW-1:0];
  assign nxt_ch = pos[POSW-1:SLW] + 1'b1;
  assign grp    = SLW'(step / SLW'(3));
  assign ph     = SLW'(step % SLW'(3));
  assign in_rng = grp < SLW'(NS);
  assign wr_now = (ph == '0) && (grp != '0) && (grp <= SLW'(NS));
  assign wr_idx = SW'(grp - 1'b1);

  // three-step schedule per stream: entry read, entry latch, data read
  always_comb begin
    cm_re   = (ph == SLW'(0)) && in_rng;
    cm_addr = {grp[SW-1:0], nxt_ch};
    dm_re   = (ph == SLW'(2)) && in_rng && !(ent_q[BITS+HI_SRC] || force_proc);
    dm_addr = ent_q[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q      <= '0;
      sel_low_q  <= 1'b0;
      oe_q       <= 1'b0;
      stage_byte <= '0;
      stage_oe   <= '0;
      wr_mask    <= '0;
    end else begin
      if (ph == SLW'(1) && in_rng) ent_q <= cm_rdata;
      if (ph == SLW'(2) && in_rng) begin
        sel_low_q <= ent_q[BITS+HI_SRC] | force_proc;
        oe_q      <= ent_q[BITS+HI_DRV] | force_proc;
      end
      if (wr_now) begin
        stage_byte[wr_idx] <= sel_low_q ? ent_q[BITS-1:0] : dm_rdata;
        stage_oe[wr_idx]   <= oe_q;
      end
      if (load)        wr_mask <= '0;
      else if (wr_now) wr_mask[wr_idx] <= 1'b1;
    end
  end

  AST_READS_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(cm_re && dm_re)); // R8
  AST_STAGE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !frame_pulse) |-> (&wr_mask)); // R8
endmodule

// File: rtl/tsw_lane.sv
module tsw_lane #(
  parameter int BITS = tsw_pkg::BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            shift,
  input  logic [BITS-1:0] load_byte,
  input  logic            load_oe,
  output logic            bit_out,
  output logic            oe_out
);
  logic [BITS-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      oe_out <= 1'b0;
    end else if (load) begin
      sh     <= load_byte;
      oe_out <= load_oe;
    end else if (shift) begin
      sh <= {sh[BITS-2:0], 1'b0};
    end
  end

  assign bit_out = sh[BITS-1];
endmodule

// File: rtl/tsw_out_stage.sv
module tsw_out_stage
  import tsw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_pulse,
  input  logic                force_proc,
  input  logic                drive_enable,
  output logic                cm_re,
  output logic [AW-1:0]       cm_addr,
  input  logic [CMW-1:0]      cm_rdata,
  output logic                dm_re,
  output logic [AW-1:0]       dm_addr,
  input  logic [BITS-1:0]     dm_rdata,
  output logic [NSTREAMS-1:0] tx_data,
  output logic [NSTREAMS-1:0] tx_en
);
  logic [POSW-1:0]                  pos;
  logic [SLW-1:0]                   step, bit_ph;
  logic                             load, shift;
  logic [NSTREAMS-1:0][BITS-1:0]    stage_byte;
  logic [NSTREAMS-1:0]              stage_oe, lane_oe;

  assign step   = pos[SLW-1:0];
  assign bit_ph = SLW'(step % SLW'(CPB));
  assign load   = frame_pulse || (step == SLW'(SLOT-1));
  assign shift  = (bit_ph == SLW'(CPB-1));

  tsw_slot_timer #(.POSW(POSW)) u_timer (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .pos(pos)
  );

  tsw_chan_fetch #(.NS(NSTREAMS)) u_fetch (
    .clk(clk), .rst_n(rst_n), .pos(pos), .load(load),
    .frame_pulse(frame_pulse), .force_proc(force_proc),
    .cm_re(cm_re), .cm_addr(cm_addr), .cm_rdata(cm_rdata),
    .dm_re(dm_re), .dm_addr(dm_addr), .dm_rdata(dm_rdata),
    .stage_byte(stage_byte), .stage_oe(stage_oe)
  );

  for (genvar g = 0; g < NSTREAMS; g++) begin : g_lane
    tsw_lane #(.BITS(BITS)) u_lane (
      .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
      .load_byte(stage_byte[g]), .load_oe(stage_oe[g]),
      .bit_out(tx_data[g]), .oe_out(lane_oe[g])
    );
    assign tx_en[g] = lane_oe[g] & drive_enable;
  end

  AST_EN_HELD_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (step != '0) |-> $stable(lane_oe)); // R7
  AST_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_ph != '0) |-> $stable(tx_data)); // R7
endmodule

// File: tb/tsw_out_stage_bench.sv
`timescale 1ns/1ps
module tsw_out_stage_bench;
  logic clk = 0, rst_n = 0, frame_pulse = 0, force_proc = 0, drive_enable = 0;
  logic cm_re, dm_re;
  logic [6:0] cm_addr, dm_addr;
  logic [15:0] cm_rdata;
  logic [7:0] dm_rdata;
  logic [3:0] tx_data, tx_en;

  always #2.5 clk = ~clk;

  tsw_out_stage u_tsw_out_stage (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .force_proc(force_proc),
    .drive_enable(drive_enable), .cm_re(cm_re), .cm_addr(cm_addr), .cm_rdata(cm_rdata),
    .dm_re(dm_re), .dm_addr(dm_addr), .dm_rdata(dm_rdata), .tx_data(tx_data), .tx_en(tx_en)
  );

  logic [15:0] cm_mem [128];
  logic [7:0]  dm_mem [128];
  always @(posedge clk) begin
    if (cm_re) cm_rdata <= cm_mem[cm_addr];
    if (dm_re) dm_rdata <= dm_mem[dm_addr];
  end

  int total = 0, bad = 0, frame_cnt = 0, ahead_seen = 0, ahead_bad = 0;
  logic [8:0] bpos;
  logic [7:0] cap_b [4][32];
  logic       cap_and [4][32], cap_or [4][32];
  logic [7:0] frm_b [4][32];
  logic       frm_and [4][32], frm_or [4][32];

  always @(posedge clk or negedge rst_n)
    if (!rst_n) bpos <= '0;
    else        bpos <= frame_pulse ? 9'd0 : bpos + 9'd1;

  always @(negedge clk) if (rst_n) begin
    for (int s = 0; s < 4; s++) begin
      cap_b[s][bpos[8:4]][7 - bpos[3:1]] = tx_data[s];
      if (bpos[3:0] == 0) begin
        cap_and[s][bpos[8:4]] = tx_en[s];
        cap_or[s][bpos[8:4]]  = tx_en[s];
      end else begin
        cap_and[s][bpos[8:4]] &= tx_en[s];
        cap_or[s][bpos[8:4]]  |= tx_en[s];
      end
    end
    if (cm_re) begin  // R8 early fetch address
      ahead_seen++;
      if (cm_addr[4:0] != 5'(bpos[8:4] + 5'd1)) ahead_bad++;
    end
    if (bpos == 9'd511) begin
      frm_b = cap_b; frm_and = cap_and; frm_or = cap_or;
      frame_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wait_frames(input int n);
    int t = frame_cnt + n;
    wait (frame_cnt >= t);
    @(negedge clk);
  endtask

  task automatic clear_cm();
    for (int i = 0; i < 128; i++) cm_mem[i] = 16'h0000;
  endtask

  task automatic chk_slot(input int s, input int c, input logic [7:0] xb, input logic xe, input string req);
    chk(frm_and[s][c] == xe && frm_or[s][c] == xe, req, {14'd0, frm_or[s][c], frm_and[s][c]}, {14'd0, xe, xe});
    if (xe) chk(frm_b[s][c] == xb, req, {8'd0, frm_b[s][c]}, {8'd0, xb});
  endtask

  typedef struct packed {
    logic [1:0] s; logic [4:0] c; logic [15:0] cm; logic [7:0] dmv;
    logic pe; logic ode; logic [7:0] xb; logic xe; logic [3:0] req;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{2'd0, 5'd5,  16'h0153, 8'hA6, 1'b0, 1'b1, 8'hA6, 1'b1, 4'd2},  // R2 stream2 ch19
    '{2'd1, 5'd10, 16'h05C6, 8'h11, 1'b0, 1'b1, 8'hC6, 1'b1, 4'd3},  // R3 constant
    '{2'd2, 5'd31, 16'h0007, 8'h3C, 1'b0, 1'b1, 8'h00, 1'b0, 4'd4},  // R4 driver off
    '{2'd3, 5'd0,  16'h0022, 8'h77, 1'b1, 1'b1, 8'h22, 1'b1, 4'd5},  // R5 global force
    '{2'd0, 5'd7,  16'h0181, 8'h5A, 1'b0, 1'b0, 8'h00, 1'b0, 4'd6},  // R6 master off
    '{2'd1, 5'd3,  16'h0444, 8'h66, 1'b1, 1'b0, 8'h00, 1'b0, 4'd6},  // R6 beats force
    '{2'd2, 5'd12, 16'h01FF, 8'hE9, 1'b0, 1'b1, 8'hE9, 1'b1, 4'd2},  // R2 bit7 ignored
    '{2'd3, 5'd31, 16'h0160, 8'h1E, 1'b0, 1'b1, 8'h1E, 1'b1, 4'd7},  // R7 last slot, MSB first
    '{2'd1, 5'd20, 16'h0406, 8'h2D, 1'b0, 1'b1, 8'h00, 1'b0, 4'd4}   // R4 constant but off
  };

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired got=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clear_cm();
    for (int i = 0; i < 128; i++) dm_mem[i] = 8'(i);
    drive_enable = 1;
    repeat (4) @(negedge clk);
    chk(tx_en == 4'h0, "R1 in reset", {12'd0, tx_en}, 16'h0);
    rst_n = 1;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (k == 5) chk(tx_en == 4'h0, "R1 first slot", {12'd0, tx_en}, 16'h0);
    end

    // table walk
    for (int i = 0; i < 9; i++) begin
      clear_cm();
      cm_mem[{VEC[i].s, VEC[i].c}] = VEC[i].cm;
      dm_mem[VEC[i].cm[6:0]]       = VEC[i].dmv;
      force_proc   = VEC[i].pe;
      drive_enable = VEC[i].ode;
      wait_frames(3);
      chk_slot(VEC[i].s, VEC[i].c, VEC[i].xb, VEC[i].xe, $sformatf("R%0d vec%0d", VEC[i].req, i));
    end

    // R9 broadcast of one source into two slots
    clear_cm(); force_proc = 0; drive_enable = 1;
    cm_mem[{2'd0, 5'd4}] = 16'h0165;
    cm_mem[{2'd2, 5'd9}] = 16'h0165;
    dm_mem[7'h65] = 8'h9A;
    wait_frames(3);
    chk_slot(0, 4, 8'h9A, 1'b1, "R9 first copy");
    chk_slot(2, 9, 8'h9A, 1'b1, "R9 second copy");
    chk_slot(1, 4, 8'h00, 1'b0, "R4 unprogrammed slot");

    // R8 fetch ran one slot ahead for the whole run
    chk(ahead_bad == 0 && ahead_seen > 0, "R8 fetch address", 16'(ahead_bad), 16'h0);

    // R10 pulse at an arbitrary position
    cm_mem[{2'd0, 5'd1}] = 16'h055B;
    wait_frames(3);
    wait (bpos == 9'd200);
    @(negedge clk);
    frame_pulse = 1;
    @(negedge clk);
    frame_pulse = 0;
    wait_frames(1);
    chk_slot(0, 1, 8'h5B, 1'b1, "R10 realigned slot1");
    chk_slot(2, 9, 8'h9A, 1'b1, "R10 realigned slot9");

    // R1 reset in mid-run
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk(tx_en == 4'h0, "R1 mid-run reset", {12'd0, tx_en}, 16'h0);
    rst_n = 1;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (k == 9) chk(tx_en == 4'h0, "R1 slot after reset", {12'd0, tx_en}, 16'h0);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule